// File: doc/BRIEF.md
# Reset and VCO Calibration Sequencer

This block is the control state machine that carries a clock generator from reset, through a settling wait and a VCO calibration, to locked normal operation. Two reset requests feed it: an active-low power-down pin (resynchronised inside the block) and an active-low software reset bit from the register interface. A power-on input acts as the asynchronous reset of every flop and counts as a pin-style reset.

When the combined reset request is released, the block leaves its reset state. A release that involved the pin or power-up also sends a one-cycle strobe that reloads the configuration defaults into the register bank. A release through the software bit alone keeps the current register contents, so the next calibration uses the current frequency plan. A settling timer then has to run a full parameterised count with the supply-good flag held high, and only then is a calibration start pulse issued. While the calibration runs, only the channels that have auto-mute enabled are muted. When calibration reports done, the mutes are released and the block waits for PLL lock before it enters normal operation. In normal operation, a loss of lock is reported but does not start a new calibration.

Top module: `vco_cal_seq`

## Requirements
- R1: While `por_n` is low, `state_o` is 0 (reset). `reload_o`, `cal_start_o`, `mute_o` and `lock_lost_o` are all 0. State codes: 0 reset, 1 settle-wait, 2 calibrate, 3 wait-lock, 4 normal.
- R2: `pdn_n` passes through a two-flop synchronizer. A low level on it forces state 0 from the third rising edge onward and holds the block there.
- R3: `swrst_n` low forces state 0 at the next rising edge, from any state.
- R4: When reset is left after a power-on or a pin reset, `reload_o` is high for exactly one cycle, the first cycle of state 1.
- R5: When reset is left after a reset made only through `swrst_n`, `reload_o` stays 0.
- R6: If the pin reset was active at any point during a reset episode, including together with the software bit, the exit issues the reload strobe.
- R7: `cal_start_o` is a one-cycle pulse in the first cycle of state 2. It is issued only after state 1 has seen HOLD_CYC consecutive cycles with `supply_ok` high. Any cycle with `supply_ok` low restarts the count.
- R8: In state 2, `mute_o` equals `automute_en` while `cal_done` is low. In every other case `mute_o` is 0, including the cycle in which `cal_done` is high.
- R9: `cal_done` high in state 2 moves the block to state 3. `pll_lock` high in state 3 moves it to state 4.
- R10: In state 4, `lock_lost_o` equals the inverse of `pll_lock`. The block stays in state 4 and no new `cal_start_o` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on indication, low = power not yet good (asynchronous reset) |
| pdn_n | input | 1 | Asynchronous power-down pin, low = hold in reset |
| swrst_n | input | 1 | Software reset bit, low = hold in reset |
| supply_ok | input | 1 | Internal supplies at their correct level |
| cal_done | input | 1 | Calibration engine finished |
| pll_lock | input | 1 | PLL lock indication |
| automute_en | input | NCH | Per-channel auto-mute enable |
| reload_o | output | 1 | One-cycle strobe: reload defaults into the register bank |
| cal_start_o | output | 1 | One-cycle calibration start pulse |
| mute_o | output | NCH | Per-channel output mute |
| state_o | output | 3 | Current sequencer state code |
| lock_lost_o | output | 1 | PLL lock lost while in normal operation |

## Verification
The assertions assume that `swrst_n`, `supply_ok`, `cal_done`, `pll_lock` and `automute_en` are synchronous to `clk`. The pin is the only input allowed to change asynchronously. They also assume that `cal_done` is raised only while a calibration is running. The stimulus changes every input one time unit after a rising edge, raises `cal_done` only in state 2, and lowers it again before any later calibration. Results are compared at the falling edge.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_WAIT   = 3'd1,
    ST_CAL    = 3'd2,
    ST_LOCK   = 3'd3,
    ST_NORMAL = 3'd4
  } seq_state_t;

  // width needed to hold the value lim
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // channels muted only while calibration is active and not yet done
  function automatic logic chan_mute(logic cal_active, logic done, logic en);
    return cal_active & ~done & en;
  endfunction

endpackage

// File: rtl/vcs_sync.sv
module vcs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/vcs_timer.sv
module vcs_timer #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned CW = vcs_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       cnt <= '0;
    else if (clr_i)    cnt <= '0;
    else if (!done_o)  cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIM);

  AST_TMR_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!arst_n)
    (done_o && LIMIT > 0) |-> !$past(clr_i)); // R7
endmodule

// File: rtl/vcs_mute.sv
module vcs_mute #(
  parameter int unsigned NCH = 4
) (
  input  logic           cal_active_i,
  input  logic           done_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] mute_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign mute_o[c] = vcs_pkg::chan_mute(cal_active_i, done_i, en_i[c]);
  end
endmodule

// File: rtl/vco_cal_seq.sv
module vco_cal_seq #(
  parameter int unsigned NCH         = 4,
  parameter int unsigned HOLD_CYC    = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           pdn_n,
  input  logic           swrst_n,
  input  logic           supply_ok,
  input  logic           cal_done,
  input  logic           pll_lock,
  input  logic [NCH-1:0] automute_en,
  output logic           reload_o,
  output logic           cal_start_o,
  output logic [NCH-1:0] mute_o,
  output logic [2:0]     state_o,
  output logic           lock_lost_o
);
  import vcs_pkg::*;

  seq_state_t state, nxt;
  logic pin_s, rst_req, pin_seen, rst_exit, tmr_done, tmr_clr, go_cal;

  vcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
    .clk(clk), .arst_n(por_n), .d_i(pdn_n), .q_o(pin_s));

  // combined reset request, pin synchronized, software bit register-synchronous
  assign rst_req  = ~pin_s | ~swrst_n;
  assign rst_exit = (state == ST_RESET) && !rst_req;

  assign tmr_clr = (state != ST_WAIT) || !supply_ok;
  vcs_timer #(.LIMIT(HOLD_CYC)) i_tmr (
    .clk(clk), .arst_n(por_n), .clr_i(tmr_clr), .done_o(tmr_done));

  assign go_cal = (state == ST_WAIT) && supply_ok && tmr_done && !rst_req;

  always_comb begin
    nxt = state;
    if (rst_req) nxt = ST_RESET;
    else begin
      unique case (state)
        ST_RESET:  nxt = ST_WAIT;
        ST_WAIT:   if (supply_ok && tmr_done) nxt = ST_CAL;
        ST_CAL:    if (cal_done) nxt = ST_LOCK;
        ST_LOCK:   if (pll_lock) nxt = ST_NORMAL;
        ST_NORMAL: nxt = ST_NORMAL;
        default:   nxt = ST_RESET;
      endcase
    end
  end

  // pin_seen: a pin-type reset (or power-on) happened in this reset episode
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state       <= ST_RESET;
      pin_seen    <= 1'b1;
      reload_o    <= 1'b0;
      cal_start_o <= 1'b0;
    end else begin
      state       <= nxt;
      reload_o    <= rst_exit && pin_seen;
      cal_start_o <= go_cal;
      if (rst_req)       pin_seen <= pin_seen | ~pin_s;
      else if (rst_exit) pin_seen <= 1'b0;
    end
  end

  vcs_mute #(.NCH(NCH)) i_mute (
    .cal_active_i(state == ST_CAL), .done_i(cal_done),
    .en_i(automute_en), .mute_o(mute_o));

  assign state_o     = state;
  assign lock_lost_o = (state == ST_NORMAL) && !pll_lock;

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> (state == ST_RESET)); // R3
  AST_RELOAD_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    reload_o |=> !reload_o); // R4
  AST_RELOAD_IN_WAIT: assert property (@(posedge clk) disable iff (!por_n)
    reload_o |-> (state == ST_WAIT || state == ST_RESET)); // R4
  AST_START_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!por_n)
    cal_start_o |-> ($past(supply_ok) && $past(state) == ST_WAIT)); // R7
  AST_MUTE_ONLY_IN_CAL: assert property (@(posedge clk) disable iff (!por_n)
    (|mute_o) |-> (state == ST_CAL)); // R8
  AST_NORMAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> $past(pll_lock)); // R9
  AST_NO_RECAL_IN_NORMAL: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_NORMAL) |-> !cal_start_o); // R10
endmodule

// File: tb/test_vco_cal_seq.sv
module test_vco_cal_seq;
  localparam int PERIOD = 10;
  localparam int NCH = 4;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic por_n, pdn_n, swrst_n, supply_ok, cal_done, pll_lock;
  logic [NCH-1:0] automute_en;
  logic reload_o, cal_start_o, lock_lost_o;
  logic [NCH-1:0] mute_o;
  logic [2:0] state_o;

  vco_cal_seq #(.NCH(NCH), .HOLD_CYC(HOLD)) i_vco_cal_seq (
    .clk(clk), .por_n(por_n), .pdn_n(pdn_n), .swrst_n(swrst_n),
    .supply_ok(supply_ok), .cal_done(cal_done), .pll_lock(pll_lock),
    .automute_en(automute_en), .reload_o(reload_o), .cal_start_o(cal_start_o),
    .mute_o(mute_o), .state_o(state_o), .lock_lost_o(lock_lost_o));

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string          tag;
    logic [2:0]     st;
    logic           rl;
    logic           cs;
    logic [NCH-1:0] mu;
    logic           ll;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // monitor: compare expected items at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (state_o !== e.st || reload_o !== e.rl || cal_start_o !== e.cs ||
            mute_o !== e.mu || lock_lost_o !== e.ll) begin
          errors++;
          $display("FAIL %s: got st=%0d rl=%b cs=%b mu=%b ll=%b, exp st=%0d rl=%b cs=%b mu=%b ll=%b",
                   e.tag, state_o, reload_o, cal_start_o, mute_o, lock_lost_o,
                   e.st, e.rl, e.cs, e.mu, e.ll);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // push one expected item for the current cycle, then advance one cycle
  task automatic expect_now(string tag, logic [2:0] st, logic rl, logic cs,
                            logic [NCH-1:0] mu, logic ll);
    exp_t e;
    e.tag = tag; e.st = st; e.rl = rl; e.cs = cs; e.mu = mu; e.ll = ll;
    q.push_back(e);
    wait (q.size() == 0);
    tick();
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; pdn_n = 1'b1; swrst_n = 1'b1; supply_ok = 1'b1;
    cal_done = 1'b0; pll_lock = 1'b0; automute_en = 4'b0101;
    tick();
    expect_now("R1 por", 3'd0, 0, 0, 4'b0, 0);
    expect_now("R1 por", 3'd0, 0, 0, 4'b0, 0);

    // power-up exit: reload strobe (R4)
    por_n = 1'b1;
    for (int i = 0; i < 3; i++) expect_now("R2 sync hold", 3'd0, 0, 0, 4'b0, 0);
    expect_now("R4 reload on power-up", 3'd1, 1, 0, 4'b0, 0);
    for (int i = 0; i < HOLD; i++) expect_now("R7 wait", 3'd1, 0, 0, 4'b0, 0);
    expect_now("R7 start", 3'd2, 0, 1, 4'b0101, 0);
    cal_done = 1'b1;
    expect_now("R8 mute released on done", 3'd2, 0, 0, 4'b0, 0);
    cal_done = 1'b0; pll_lock = 1'b1;
    expect_now("R9 lock wait", 3'd3, 0, 0, 4'b0, 0);
    expect_now("R9 normal", 3'd4, 0, 0, 4'b0, 0);
    pll_lock = 1'b0;
    expect_now("R10 lock lost", 3'd4, 0, 0, 4'b0, 1);
    expect_now("R10 no recal", 3'd4, 0, 0, 4'b0, 1);
    pll_lock = 1'b1;
    expect_now("R10 relock", 3'd4, 0, 0, 4'b0, 0);

    // software reset: no reload, supply drop restarts timer
    swrst_n = 1'b0;
    expect_now("R3 before edge", 3'd4, 0, 0, 4'b0, 0);
    expect_now("R3 sw reset", 3'd0, 0, 0, 4'b0, 0);
    swrst_n = 1'b1;
    expect_now("R3 release edge", 3'd0, 0, 0, 4'b0, 0);
    expect_now("R5 no reload", 3'd1, 0, 0, 4'b0, 0);
    for (int i = 0; i < 4; i++) expect_now("R7 wait", 3'd1, 0, 0, 4'b0, 0);
    supply_ok = 1'b0;
    expect_now("R7 supply low", 3'd1, 0, 0, 4'b0, 0);
    supply_ok = 1'b1; automute_en = 4'b1010;
    expect_now("R7 restart", 3'd1, 0, 0, 4'b0, 0);
    for (int i = 0; i < HOLD; i++) expect_now("R7 restarted wait", 3'd1, 0, 0, 4'b0, 0);
    expect_now("R7 start after restart", 3'd2, 0, 1, 4'b1010, 0);

    // both sources together from calibration: reload on exit (R6)
    pdn_n = 1'b0; swrst_n = 1'b0;
    expect_now("R8 cal mute", 3'd2, 0, 0, 4'b1010, 0);
    expect_now("R3 reset from cal", 3'd0, 0, 0, 4'b0, 0);
    tick(); tick();
    swrst_n = 1'b1;
    expect_now("R2 pin holds", 3'd0, 0, 0, 4'b0, 0);
    expect_now("R2 pin holds", 3'd0, 0, 0, 4'b0, 0);
    pdn_n = 1'b1;
    for (int i = 0; i < 3; i++) expect_now("R2 sync release", 3'd0, 0, 0, 4'b0, 0);
    expect_now("R6 reload after both", 3'd1, 1, 0, 4'b0, 0);
    expect_now("R4 one-cycle strobe", 3'd1, 0, 0, 4'b0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule